// File: doc/BRIEF.md
# Indirect Memory Access Window

This block places a 256-byte storage array behind two locations of a simple register bus. One location holds a byte pointer; the other is a window onto the byte the pointer selects. Software loads the pointer once and then streams bytes through the window. Every read or write of the window moves the pointer on by one, so a run of accesses walks through consecutive bytes without touching the pointer again.

The bus side is a plain strobe interface: a select line, separate read and write strobes, an index that picks the location, and 8-bit write and read data. Read results appear on the read-data output at the clock edge that takes the read strobe. They stay there until the next read. The storage array and the pointer have no reset value. Only the read-data register is cleared by reset.

Top module: `sram_window`

## Requirements
- R1: A read strobe with select high at index 19h returns, on `rd_data` from the next rising edge, the byte stored at the current pointer value.
- R2: A write strobe with select high at index 19h stores `wr_data` at the current pointer value.
- R3: Every read or write at index 19h advances the pointer by one, so consecutive window reads return bytes from consecutive locations.
- R4: A window access made while the pointer is FFh leaves the pointer at 00h.
- R5: A write at index 18h loads `wr_data` into the pointer without any increment. The next window access uses the loaded value.
- R6: A read at index 18h returns the current pointer on `rd_data` from the next rising edge and leaves the pointer unchanged.
- R7: Strobes with select low, and writes to any index other than 18h or 19h, change neither the pointer nor the stored bytes. A read of any other index returns 00h.
- R8: When both strobes are high in the same cycle, only the write takes place and `rd_data` keeps its previous value.
- R9: While `rst_n` is low at a rising edge, `rd_data` becomes 00h.
- R10: `rd_data` holds its value in every cycle that has no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the read-data register |
| bus_sel | input | 1 | Selects this block for the current cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | 8 | Register index: 18h is the pointer, 19h is the data window |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
The bench builds the block with its default parameters: an 8-bit pointer over 256 bytes, 8-bit data, and the two locations at 18h and 19h. With an 8-bit pointer the wrap from FFh to 00h takes only two window accesses after loading FEh. The bench can therefore reach the wrap directly and read it back through the pointer location. The same default widths mean every pointer value fits in one data byte, so the pointer is fully observable through a read of 18h.

// File: rtl/sram_win_pkg.sv
// Package: shared access-kind type for the indirect memory window.
// Assumes one bus access per cycle at most; the decoder resolves overlaps.
package sram_win_pkg;

    // Kind of access the current bus cycle performs.
    typedef enum logic [2:0] {
        ACC_NONE    = 3'd0,
        ACC_PTR_RD  = 3'd1,
        ACC_PTR_WR  = 3'd2,
        ACC_DAT_RD  = 3'd3,
        ACC_DAT_WR  = 3'd4,
        ACC_OTH_RD  = 3'd5
    } acc_e;

endpackage

// File: rtl/win_decode.sv
// Module: win_decode
// Turns select, strobes and index into a single access kind per cycle.
// Assumes: a write strobe wins over a read strobe in the same cycle;
// writes to unknown indices are dropped, reads of them are flagged.
module win_decode
    import sram_win_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int PTR_IDX = 8'h18,
    parameter int DAT_IDX = 8'h19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             rd,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    output acc_e             acc
);

    localparam logic [IDX_W-1:0] PTR_CODE = IDX_W'(PTR_IDX);
    localparam logic [IDX_W-1:0] DAT_CODE = IDX_W'(DAT_IDX);

    logic hit_ptr;
    logic hit_dat;

    // Compare the index against both known locations.
    always_comb begin
        hit_ptr = (idx == PTR_CODE);
        hit_dat = (idx == DAT_CODE);
    end

    // Classify the cycle; write has priority over read.
    always_comb begin
        acc = ACC_NONE;
        if (sel && wr) begin
            if (hit_ptr)      acc = ACC_PTR_WR;
            else if (hit_dat) acc = ACC_DAT_WR;
            else              acc = ACC_NONE;
        end else if (sel && rd) begin
            if (hit_ptr)      acc = ACC_PTR_RD;
            else if (hit_dat) acc = ACC_DAT_RD;
            else              acc = ACC_OTH_RD;
        end
    end

    // R8: a cycle with both strobes never becomes a read.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd && wr) |-> (acc != ACC_PTR_RD && acc != ACC_DAT_RD && acc != ACC_OTH_RD));

    // R7: with select low the cycle performs nothing.
    a_r7_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (acc == ACC_NONE));

endmodule

// File: rtl/win_pointer.sv
// Module: win_pointer
// Byte pointer of the window: loaded by a pointer write, advanced by one
// after every data access, wrapping at the top of the address space.
// Assumes: no reset value (rst_n only gates the checks).
module win_pointer
    import sram_win_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_e              acc,
    input  logic [DATA_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] PTR_TOP = '1;

    logic data_acc;

    // Flag cycles that touch the data window.
    always_comb begin
        data_acc = (acc == ACC_DAT_RD) || (acc == ACC_DAT_WR);
    end

    // Load on pointer write, else step after a data access.
    always_ff @(posedge clk) begin
        if (acc == ACC_PTR_WR) begin
            ptr <= ADDR_W'(load_val);
        end else if (data_acc) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R3: a data access moves the pointer on by exactly one.
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R4: the top address wraps to zero.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ptr == PTR_TOP) |=> (ptr == '0));

    // R5: a pointer write loads the written value.
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_PTR_WR) |=> (ptr == ADDR_W'($past(load_val))));

    // R6/R7: any other cycle leaves the pointer alone.
    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_NONE || acc == ACC_PTR_RD || acc == ACC_OTH_RD) |=> $stable(ptr));

endmodule

// File: rtl/win_store.sv
// Module: win_store
// Storage array behind the window: synchronous write, combinational read.
// Assumes: contents undefined until written; one write port, one read port.
module win_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the selected byte when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the byte under the pointer.
    always_comb begin
        rdata = mem[addr];
    end

    // R2: a written byte is found at its address on the next cycle.
    a_r2_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/sram_window.sv
// Module: sram_window (top)
// Indirect access window: pointer at one index, data window at another,
// storage array inside. Reads are returned through a registered output.
// Assumes: one access per cycle; only the read-data register is reset.
module sram_window
    import sram_win_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 8,
    parameter int PTR_IDX = 8'h18,
    parameter int DAT_IDX = 8'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    acc_e              acc;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] mem_byte;
    logic              mem_we;
    logic [DATA_W-1:0] rd_q;
    logic              is_read;

    win_decode #(
        .IDX_W   (IDX_W),
        .PTR_IDX (PTR_IDX),
        .DAT_IDX (DAT_IDX)
    ) decode_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .idx   (bus_idx),
        .acc   (acc)
    );

    win_pointer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) pointer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .load_val (wr_data),
        .ptr      (ptr)
    );

    // Enable the array write only for data-window writes.
    always_comb begin
        mem_we  = (acc == ACC_DAT_WR);
        is_read = (acc == ACC_PTR_RD) || (acc == ACC_DAT_RD) || (acc == ACC_OTH_RD);
    end

    win_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (mem_byte)
    );

    // Capture the read result, sampling memory before the pointer steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            case (acc)
                ACC_PTR_RD: rd_q <= DATA_W'(ptr);
                ACC_DAT_RD: rd_q <= mem_byte;
                ACC_OTH_RD: rd_q <= '0;
                default:    rd_q <= rd_q;
            endcase
        end
    end

    assign rd_data = rd_q;

    // R6: a pointer read returns the pointer value of that cycle.
    a_r6_ptr_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_PTR_RD) |=> (rd_data == DATA_W'($past(ptr))));

    // R10: without a read the output does not move.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> $stable(rd_data));

    // R7: a read of an unknown index returns zero.
    a_r7_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_OTH_RD) |=> (rd_data == '0));

endmodule

// File: tb/sram_window_tb_top.sv
// Bench for sram_window: a vector table walked by one loop, then directed
// tests for reset, ignored accesses, strobe overlap and output hold.
module sram_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [7:0] IP = 8'h18;
    localparam logic [7:0] ID = 8'h19;

    // Vector: {rd, wr, idx[7:0], data[7:0]}; data is the write value or expected read.
    localparam int NV = 22;
    localparam logic [17:0] VEC [NV] = '{
        {2'b01, IP, 8'h10}, {2'b01, ID, 8'hA1}, {2'b01, ID, 8'hB2}, {2'b01, ID, 8'hC3},
        {2'b10, IP, 8'h13},
        {2'b01, IP, 8'h10}, {2'b10, ID, 8'hA1}, {2'b10, ID, 8'hB2}, {2'b10, ID, 8'hC3},
        {2'b10, IP, 8'h13},
        {2'b01, IP, 8'h80}, {2'b10, IP, 8'h80},
        {2'b01, IP, 8'hFE}, {2'b01, ID, 8'h5A}, {2'b01, ID, 8'h6B}, {2'b10, IP, 8'h00},
        {2'b01, IP, 8'hFE}, {2'b10, ID, 8'h5A}, {2'b10, ID, 8'h6B}, {2'b10, IP, 8'h00},
        {2'b01, IP, 8'h11}, {2'b10, ID, 8'hB2}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_window dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_sel (bus_sel),
        .bus_rd  (bus_rd),
        .bus_wr  (bus_wr),
        .bus_idx (bus_idx),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, drop strobes at the next one.
    task automatic cycle(input logic s, input logic r, input logic w,
                         input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        bus_sel = s; bus_rd = r; bus_wr = w; bus_idx = i; wr_data = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] held;
        // R9: reset clears the output register.
        repeat (3) @(negedge clk);
        check("R9 reset value", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", rd_data, 8'h00);

        // Table walk: R1, R2, R3, R4, R5, R6.
        for (int k = 0; k < NV; k++) begin
            if (VEC[k][16]) begin
                cycle(1'b1, 1'b0, 1'b1, VEC[k][15:8], VEC[k][7:0]);
            end else begin
                cycle(1'b1, 1'b1, 1'b0, VEC[k][15:8], 8'h00);
                check((VEC[k][15:8] == ID) ? "R1/R3 window read" : "R6/R4/R5 pointer read",
                      rd_data, VEC[k][7:0]);
            end
        end

        // R10: output holds through idle cycles after a read of B2.
        repeat (4) @(negedge clk);
        check("R10 hold", rd_data, 8'hB2);

        // R7: write to data window with select low is ignored.
        cycle(1'b1, 1'b0, 1'b1, IP, 8'h20);
        cycle(1'b0, 1'b0, 1'b1, ID, 8'hEE);
        cycle(1'b1, 1'b1, 1'b0, IP, 8'h00);
        check("R7 no select keeps pointer", rd_data, 8'h20);
        // R7: write to an unknown index touches nothing.
        cycle(1'b1, 1'b0, 1'b1, 8'h2C, 8'h33);
        cycle(1'b1, 1'b1, 1'b0, IP, 8'h00);
        check("R7 unknown write keeps pointer", rd_data, 8'h20);
        // R7: unknown read returns zero.
        cycle(1'b1, 1'b1, 1'b0, 8'h2C, 8'h00);
        check("R7 unknown read", rd_data, 8'h00);
        // R7: memory at 10h..12h still holds the table bytes.
        cycle(1'b1, 1'b0, 1'b1, IP, 8'h10);
        cycle(1'b1, 1'b1, 1'b0, ID, 8'h00);
        check("R7 memory intact", rd_data, 8'hA1);

        // R8: both strobes -> write only, output holds A1.
        cycle(1'b1, 1'b0, 1'b1, IP, 8'h40);
        cycle(1'b1, 1'b1, 1'b1, ID, 8'h77);
        check("R8 output held", rd_data, 8'hA1);
        cycle(1'b1, 1'b1, 1'b0, IP, 8'h00);
        check("R8 pointer stepped", rd_data, 8'h41);
        cycle(1'b1, 1'b0, 1'b1, IP, 8'h40);
        cycle(1'b1, 1'b1, 1'b0, ID, 8'h00);
        check("R8 byte written", rd_data, 8'h77);

        // R2/R3: back-to-back writes with no idle cycle, then read back.
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b0; bus_wr = 1'b1; bus_idx = IP; wr_data = 8'h60;
        @(negedge clk);
        bus_idx = ID; wr_data = 8'h01;
        @(negedge clk);
        wr_data = 8'h02;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_idx = IP;
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
        check("R3 back-to-back pointer", rd_data, 8'h62);
        cycle(1'b1, 1'b0, 1'b1, IP, 8'h61);
        cycle(1'b1, 1'b1, 1'b0, ID, 8'h00);
        check("R2 back-to-back byte", rd_data, 8'h02);

        // R9: reset mid-run clears the output again.
        held = rd_data;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears output", rd_data, 8'h00);
        rst_n = 1'b1;
        cycle(1'b1, 1'b1, 1'b0, IP, 8'h00);
        check("R9 pointer kept through reset", rd_data, 8'h62);
        if (held == 8'h00) $display("note: held value was zero");

        done = 1'b1;
        finish_run();
    end

endmodule